// File: doc/BRIEF.md
# USB Host Clock and Reset Bring-Up Sequencer

This block is a small hardware controller that brings a combined high-speed/full-speed USB host controller and its two-port PHY out of reset. Software or a power manager raises a start request. The sequencer then works through a fixed list of steps, each taking effect on its own clock edge, and holds timed waits between some of them. The steps enable the host interface, load the PHY transmit tuning, choose and divide the reference clock, derive the host clock divider from the I/O clock frequency, and release the divider, PHY and host resets in the safe order. Every wait length is a parameter in I/O clock cycles.

Several host functions share the same clock and reset tree, so start requests are reference-counted. Only the request that finds the use count at zero, with the sequencer idle, starts the sequence. A stop request only lowers the count. If the host reset has already been released when the reset check step is reached, the clock and reset steps are skipped and only the frame-length value is written. Completion is signalled by a one-cycle done pulse. An unsupported reference rate is flagged.

Top module: `usbh_bringup_seq`

## Requirements
- R1: While reset is high and after it is released, every output is 0 until the first sequence step takes effect.
- R2: A start request without a stop request, seen on a clock edge while the use count is 0 and the sequencer is idle, launches the sequence, and the count goes up by 1. A stop request without a start request lowers the count by 1, and a stop at count 0 is ignored. A start and a stop on the same edge change nothing and launch nothing.
- R3: One edge after the launch edge, if_en goes to 1 and stays at 1 until reset. On the next edge, each PHY port p takes voltage-reference tune 15 in tx_vref_tune[4p+3:4p], rise tune 1 in tx_rise_tune[2p+1:2p] and pre-emphasis tune 1 in tx_preemph_tune[p].
- R4: If host_rst_rel is already 1 when the sequence reaches its check step, the skip path is taken. The frame-length write and the done pulse then land 4 edges after the launch edge, and no reset, divider or reference output changes.
- R5: On the full path, 4 edges after the launch edge, phy_por goes to 1. On the same edge, host_rst_rel, phy_rst_drv, host_div_en, host_div_run, ohci_div_en and ohci_div_run all go to 0.
- R6: 5 edges after the launch edge, refclk_sel is set to 0 for a crystal and 1 for an external clock. refclk_div is set to 0 for 12 MHz, 1 for 24 MHz and 2 for 48 MHz. Any other rate sets bad_rate to 1 and refclk_div to 0. bad_rate holds its value until the next full run or reset.
- R7: 6 edges after the launch edge, host_div is loaded from q = floor(io_clk_hz / 130 MHz) as follows: q of 0 or 1 gives 1; q of 2, 3 or 4 passes through unchanged; q of 5 gives 4; q of 6 or 7 gives 6; q of 8 to 11 gives 8; q of 12 or more gives 12. The inputs are captured on the launch edge.
- R8: On the full path, host_div_en rises 7 edges after the launch edge and host_div_run rises at 8. phy_por falls WAIT_DIV_CYC edges later. ohci_div_run rises WAIT_POR_CYC edges after that, and ohci_div_en rises one edge after ohci_div_run.
- R9: WAIT_DIV_CYC edges after ohci_div_en rises, phy_rst_drv goes to 1. It goes to 0 WAIT_PHYHI_CYC edges later and back to 1 after a further WAIT_PHYLO_CYC edges. host_rst_rel rises WAIT_PHYHI_CYC edges after that.
- R10: On both paths, the final step sets fla_adj to 0x20 and raises done for exactly one cycle. On the full path this happens one edge after host_rst_rel rises.
- R11: Start requests that arrive while a sequence is running raise the count but do not restart the sequence or add a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Use request (count up, launch from zero) |
| stop_req | input | 1 | Release request (count down) |
| io_clk_hz | input | 32 | I/O clock frequency in Hz |
| ref_clk_hz | input | 32 | Reference clock rate in Hz |
| ref_is_crystal | input | 1 | 1 when the reference is a crystal |
| if_en | output | 1 | Host interface clock enable |
| tx_vref_tune | output | 4*NPORT | Per-port TX voltage reference tune |
| tx_rise_tune | output | 2*NPORT | Per-port TX rise-time tune |
| tx_preemph_tune | output | NPORT | Per-port TX pre-emphasis tune |
| refclk_sel | output | 1 | Reference select (0 crystal, 1 external) |
| refclk_div | output | 2 | Reference divider code |
| host_div | output | 4 | Host clock divider value |
| host_div_en | output | 1 | Host clock divider enable |
| host_div_run | output | 1 | Host clock divider out of reset |
| ohci_div_en | output | 1 | Full-speed clock divider enable |
| ohci_div_run | output | 1 | Full-speed clock divider out of reset |
| phy_por | output | 1 | PHY power-on reset (1 = asserted) |
| phy_rst_drv | output | 1 | PHY reset control level |
| host_rst_rel | output | 1 | Host reset released (1 = running) |
| fla_adj | output | 6 | Frame length adjust value |
| done | output | 1 | One-cycle completion pulse |
| bad_rate | output | 1 | Unsupported reference rate seen |

## Verification
The skip path is the hardest state to reach. It needs host_rst_rel already high at the check step, which only a completed full run produces, and a fresh launch, which needs the use count to return to zero without a reset. The stimulus therefore completes a full run, piles extra starts on top of it while it is running, and issues matching stops, including one surplus stop at zero. It then tries a start and a stop on the same edge, and only then relaunches into the skip path. Each host divider band is reached by resetting between full runs and sweeping io_clk_hz across every lookup boundary.

// File: rtl/usbh_seq_pkg.sv
package usbh_seq_pkg;

    typedef enum logic [4:0] {
        ST_IDLE, ST_IFEN, ST_TUNE, ST_CHK, ST_RST0, ST_REF, ST_HDIV,
        ST_HEN, ST_HRUN, ST_PORREL, ST_ORUN, ST_OEN, ST_PRST1,
        ST_PRST0, ST_PRST2, ST_HREL, ST_FLA, ST_WAIT
    } seq_state_e;

    typedef struct packed {
        logic if_en;
        logic phy_por;
        logic phy_rst;
        logic host_rel;
        logic hdiv_en;
        logic hdiv_run;
        logic odiv_en;
        logic odiv_run;
    } ctl_t;

    typedef struct packed {
        logic [1:0] code;
        logic       bad;
    } ref_cfg_t;

    localparam logic [3:0] TUNE_VREF    = 4'd15;
    localparam logic [1:0] TUNE_RISE    = 2'd1;
    localparam logic       TUNE_PREEMPH = 1'b1;
    localparam logic [5:0] FLA_VALUE    = 6'h20;

    function automatic ref_cfg_t ref_decode(input logic [31:0] hz);
        ref_cfg_t r;
        r.bad = 1'b0;
        case (hz)
            32'd12_000_000: r.code = 2'd0;
            32'd24_000_000: r.code = 2'd1;
            32'd48_000_000: r.code = 2'd2;
            default: begin
                r.code = 2'd0;
                r.bad  = 1'b1;
            end
        endcase
        return r;
    endfunction

    // Band selection by threshold compares; no divider needed.
    function automatic logic [3:0] host_div_lookup(input logic [31:0] hz,
                                                   input logic [31:0] base);
        logic [63:0] f;
        logic [63:0] b;
        f = {32'd0, hz};
        b = {32'd0, base};
        if (f >= 64'd12 * b)     return 4'd12;
        else if (f >= 64'd8 * b) return 4'd8;
        else if (f >= 64'd6 * b) return 4'd6;
        else if (f >= 64'd4 * b) return 4'd4;
        else if (f >= 64'd3 * b) return 4'd3;
        else if (f >= 64'd2 * b) return 4'd2;
        else                     return 4'd1;
    endfunction

endpackage

// File: rtl/usbh_use_count.sv
module usbh_use_count #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic stop_req,
    input  logic idle,
    output logic launch
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic             up;
    logic             down;

    assign up     = start_req && !stop_req;
    assign down   = stop_req && !start_req;
    assign launch = up && (cnt == '0) && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (up && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end else if (down && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/usbh_wait_timer.sv
module usbh_wait_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             expired
);
    logic [TMR_W-1:0] remain;

    assign expired = (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/usbh_clk_cfg.sv
module usbh_clk_cfg
    import usbh_seq_pkg::*;
#(
    parameter int DIV_BASE_HZ = 130_000_000
) (
    input  logic [31:0] io_hz,
    input  logic [31:0] ref_hz,
    output ref_cfg_t    ref_cfg,
    output logic [3:0]  hdiv_val
);
    localparam logic [31:0] BASE = 32'(DIV_BASE_HZ);

    always_comb begin
        ref_cfg  = ref_decode(ref_hz);
        hdiv_val = host_div_lookup(io_hz, BASE);
    end
endmodule

// File: rtl/usbh_bringup_seq.sv
module usbh_bringup_seq
    import usbh_seq_pkg::*;
#(
    parameter int NPORT          = 2,
    parameter int CNT_W          = 4,
    parameter int DIV_BASE_HZ    = 130_000_000,
    parameter int WAIT_DIV_CYC   = 64,
    parameter int WAIT_POR_CYC   = 2_400_000,
    parameter int WAIT_PHYLO_CYC = 800_000,
    parameter int WAIT_PHYHI_CYC = 800
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_req,
    input  logic               stop_req,
    input  logic [31:0]        io_clk_hz,
    input  logic [31:0]        ref_clk_hz,
    input  logic               ref_is_crystal,
    output logic               if_en,
    output logic [4*NPORT-1:0] tx_vref_tune,
    output logic [2*NPORT-1:0] tx_rise_tune,
    output logic [NPORT-1:0]   tx_preemph_tune,
    output logic               refclk_sel,
    output logic [1:0]         refclk_div,
    output logic [3:0]         host_div,
    output logic               host_div_en,
    output logic               host_div_run,
    output logic               ohci_div_en,
    output logic               ohci_div_run,
    output logic               phy_por,
    output logic               phy_rst_drv,
    output logic               host_rst_rel,
    output logic [5:0]         fla_adj,
    output logic               done,
    output logic               bad_rate
);
    // Each wait spans N edges between two actions: one load edge,
    // N-2 countdown edges, one edge to step to the next action.
    localparam int WMAX_A = (WAIT_DIV_CYC > WAIT_POR_CYC) ? WAIT_DIV_CYC : WAIT_POR_CYC;
    localparam int WMAX_B = (WAIT_PHYLO_CYC > WAIT_PHYHI_CYC) ? WAIT_PHYLO_CYC : WAIT_PHYHI_CYC;
    localparam int WMAX   = (WMAX_A > WMAX_B) ? WMAX_A : WMAX_B;
    localparam int TMR_W  = $clog2(WMAX + 1);
    localparam logic [TMR_W-1:0] LD_DIV   = TMR_W'(WAIT_DIV_CYC - 2);
    localparam logic [TMR_W-1:0] LD_POR   = TMR_W'(WAIT_POR_CYC - 2);
    localparam logic [TMR_W-1:0] LD_PHYLO = TMR_W'(WAIT_PHYLO_CYC - 2);
    localparam logic [TMR_W-1:0] LD_PHYHI = TMR_W'(WAIT_PHYHI_CYC - 2);

    seq_state_e       state;
    seq_state_e       ret_state;
    ctl_t             ctl;
    logic             launch;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    logic [31:0]      io_q;
    logic [31:0]      ref_q;
    logic             xtal_q;
    ref_cfg_t         rcfg;
    logic [3:0]       hdiv_val;
    logic [4*NPORT-1:0] vref_r;
    logic [2*NPORT-1:0] rise_r;
    logic [NPORT-1:0]   pre_r;

    usbh_use_count #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .stop_req  (stop_req),
        .idle      (state == ST_IDLE),
        .launch    (launch)
    );

    usbh_wait_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    usbh_clk_cfg #(.DIV_BASE_HZ(DIV_BASE_HZ)) u_cfg (
        .io_hz    (io_q),
        .ref_hz   (ref_q),
        .ref_cfg  (rcfg),
        .hdiv_val (hdiv_val)
    );

    always_comb begin
        tmr_load = 1'b1;
        unique case (state)
            ST_HRUN:   tmr_val = LD_DIV;
            ST_PORREL: tmr_val = LD_POR;
            ST_OEN:    tmr_val = LD_DIV;
            ST_PRST1:  tmr_val = LD_PHYHI;
            ST_PRST0:  tmr_val = LD_PHYLO;
            ST_PRST2:  tmr_val = LD_PHYHI;
            default: begin
                tmr_load = 1'b0;
                tmr_val  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ret_state  <= ST_IDLE;
            ctl        <= '0;
            vref_r     <= '0;
            rise_r     <= '0;
            pre_r      <= '0;
            refclk_sel <= 1'b0;
            refclk_div <= 2'd0;
            host_div   <= 4'd0;
            fla_adj    <= 6'd0;
            done       <= 1'b0;
            bad_rate   <= 1'b0;
            io_q       <= '0;
            ref_q      <= '0;
            xtal_q     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (launch) begin
                    io_q   <= io_clk_hz;
                    ref_q  <= ref_clk_hz;
                    xtal_q <= ref_is_crystal;
                    state  <= ST_IFEN;
                end
                ST_IFEN: begin
                    ctl.if_en <= 1'b1;
                    state     <= ST_TUNE;
                end
                ST_TUNE: begin
                    vref_r <= {NPORT{TUNE_VREF}};
                    rise_r <= {NPORT{TUNE_RISE}};
                    pre_r  <= {NPORT{TUNE_PREEMPH}};
                    state  <= ST_CHK;
                end
                ST_CHK: state <= ctl.host_rel ? ST_FLA : ST_RST0;
                ST_RST0: begin
                    ctl.phy_por  <= 1'b1;
                    ctl.host_rel <= 1'b0;
                    ctl.phy_rst  <= 1'b0;
                    ctl.hdiv_en  <= 1'b0;
                    ctl.hdiv_run <= 1'b0;
                    ctl.odiv_en  <= 1'b0;
                    ctl.odiv_run <= 1'b0;
                    state        <= ST_REF;
                end
                ST_REF: begin
                    refclk_sel <= ~xtal_q;
                    refclk_div <= rcfg.code;
                    bad_rate   <= rcfg.bad;
                    state      <= ST_HDIV;
                end
                ST_HDIV: begin
                    host_div <= hdiv_val;
                    state    <= ST_HEN;
                end
                ST_HEN: begin
                    ctl.hdiv_en <= 1'b1;
                    state       <= ST_HRUN;
                end
                ST_HRUN: begin
                    ctl.hdiv_run <= 1'b1;
                    ret_state    <= ST_PORREL;
                    state        <= ST_WAIT;
                end
                ST_PORREL: begin
                    ctl.phy_por <= 1'b0;
                    ret_state   <= ST_ORUN;
                    state       <= ST_WAIT;
                end
                ST_ORUN: begin
                    ctl.odiv_run <= 1'b1;
                    state        <= ST_OEN;
                end
                ST_OEN: begin
                    ctl.odiv_en <= 1'b1;
                    ret_state   <= ST_PRST1;
                    state       <= ST_WAIT;
                end
                ST_PRST1: begin
                    ctl.phy_rst <= 1'b1;
                    ret_state   <= ST_PRST0;
                    state       <= ST_WAIT;
                end
                ST_PRST0: begin
                    ctl.phy_rst <= 1'b0;
                    ret_state   <= ST_PRST2;
                    state       <= ST_WAIT;
                end
                ST_PRST2: begin
                    ctl.phy_rst <= 1'b1;
                    ret_state   <= ST_HREL;
                    state       <= ST_WAIT;
                end
                ST_HREL: begin
                    ctl.host_rel <= 1'b1;
                    state        <= ST_FLA;
                end
                ST_FLA: begin
                    fla_adj <= FLA_VALUE;
                    done    <= 1'b1;
                    state   <= ST_IDLE;
                end
                ST_WAIT: if (tmr_expired) state <= ret_state;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign if_en           = ctl.if_en;
    assign tx_vref_tune    = vref_r;
    assign tx_rise_tune    = rise_r;
    assign tx_preemph_tune = pre_r;
    assign host_div_en     = ctl.hdiv_en;
    assign host_div_run    = ctl.hdiv_run;
    assign ohci_div_en     = ctl.odiv_en;
    assign ohci_div_run    = ctl.odiv_run;
    assign phy_por         = ctl.phy_por;
    assign phy_rst_drv     = ctl.phy_rst;
    assign host_rst_rel    = ctl.host_rel;
endmodule

// File: rtl/usbh_bringup_seq_chk.sv
module usbh_bringup_seq_chk #(
    parameter int NPORT = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               if_en,
    input logic [4*NPORT-1:0] tx_vref_tune,
    input logic [1:0]         refclk_div,
    input logic [3:0]         host_div,
    input logic               host_div_en,
    input logic               host_div_run,
    input logic               ohci_div_en,
    input logic               ohci_div_run,
    input logic               phy_por,
    input logic               phy_rst_drv,
    input logic               host_rst_rel,
    input logic [5:0]         fla_adj,
    input logic               done,
    input logic               bad_rate
);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_fla_on_done_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> fla_adj == 6'h20);

    assert_host_rel_order_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(host_rst_rel) |-> (phy_rst_drv && !phy_por && ohci_div_en
                                 && ohci_div_run && host_div_run));

    assert_por_entry_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_por) |-> (!host_rst_rel && !phy_rst_drv && !host_div_en
                            && !ohci_div_en));

    assert_div_legal_R7: assert property (@(posedge clk) disable iff (rst)
        host_div_en |-> (host_div inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12}));

    assert_bad_code_R6: assert property (@(posedge clk) disable iff (rst)
        bad_rate |-> refclk_div == 2'd0);

    assert_ifen_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        if_en |=> if_en);

    assert_run_after_en_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(host_div_run) |-> host_div_en && if_en && tx_vref_tune != '0);
endmodule

bind usbh_bringup_seq usbh_bringup_seq_chk #(.NPORT(NPORT)) u_chk (.*);

// File: tb/test_usbh_bringup_seq.sv
module test_usbh_bringup_seq;
    localparam int NP = 2;
    localparam int WD = 8;
    localparam int WP = 40;
    localparam int WL = 20;
    localparam int WH = 4;

    logic clk = 0;
    logic rst = 1;
    logic start_req = 0;
    logic stop_req = 0;
    logic [31:0] io_clk_hz = 32'd800_000_000;
    logic [31:0] ref_clk_hz = 32'd12_000_000;
    logic ref_is_crystal = 0;
    logic if_en, refclk_sel, host_div_en, host_div_run, ohci_div_en, ohci_div_run;
    logic phy_por, phy_rst_drv, host_rst_rel, done, bad_rate;
    logic [4*NP-1:0] tx_vref_tune;
    logic [2*NP-1:0] tx_rise_tune;
    logic [NP-1:0] tx_preemph_tune;
    logic [1:0] refclk_div;
    logic [3:0] host_div;
    logic [5:0] fla_adj;

    always #2.5 clk = ~clk;

    usbh_bringup_seq #(.NPORT(NP), .CNT_W(4), .WAIT_DIV_CYC(WD), .WAIT_POR_CYC(WP),
        .WAIT_PHYLO_CYC(WL), .WAIT_PHYHI_CYC(WH)) i_usbh_bringup_seq (.*);

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int done_seen = 0;

    // ---------------- reference model ----------------
    typedef struct { int at; int id; } ev_t;
    ev_t evq[$];
    localparam int E_IFEN = 1, E_TUNE = 2, E_RST0 = 3, E_REF = 4, E_HDIV = 5, E_HEN = 6,
                   E_HRUN = 7, E_POR = 8, E_ORUN = 9, E_OEN = 10, E_PR1 = 11, E_PR0 = 12,
                   E_PR2 = 13, E_HREL = 14, E_FLA = 15;
    int m_cnt, m_launches;
    bit m_busy;
    int m_io, m_ref;
    bit m_xtal;
    bit e_if, e_sel, e_hen, e_hrun, e_oen, e_orun, e_por, e_prst, e_hrel, e_done, e_bad;
    logic [4*NP-1:0] e_vref;
    logic [2*NP-1:0] e_rise;
    logic [NP-1:0] e_pre;
    logic [1:0] e_rdiv;
    logic [3:0] e_hdiv;
    logic [5:0] e_fla;

    function automatic logic [3:0] exp_hdiv(input int io);
        longint q = longint'(io) / 130_000_000;
        if (q == 0) return 1;
        if (q <= 4) return 4'(q);
        if (q == 5) return 4;
        if (q <= 7) return 6;
        if (q <= 11) return 8;
        return 12;
    endfunction

    task automatic m_reset();
        evq.delete();
        m_cnt = 0; m_busy = 0;
        {e_if, e_sel, e_hen, e_hrun, e_oen, e_orun, e_por, e_prst, e_hrel, e_done, e_bad} = '0;
        e_vref = '0; e_rise = '0; e_pre = '0; e_rdiv = 0; e_hdiv = 0; e_fla = 0;
    endtask

    task automatic push(input int at, input int id);
        ev_t e;
        e.at = at; e.id = id;
        evq.push_back(e);
    endtask

    task automatic m_launch();
        int t, p, o;
        t = cyc;
        m_busy = 1; m_launches++;
        m_io = io_clk_hz; m_ref = ref_clk_hz; m_xtal = ref_is_crystal;
        push(t + 1, E_IFEN); push(t + 2, E_TUNE);
        if (e_hrel) begin
            push(t + 4, E_FLA);
        end else begin
            push(t + 4, E_RST0); push(t + 5, E_REF); push(t + 6, E_HDIV);
            push(t + 7, E_HEN); push(t + 8, E_HRUN);
            p = t + 8 + WD; push(p, E_POR);
            push(p + WP, E_ORUN);
            o = p + WP + 1; push(o, E_OEN);
            push(o + WD, E_PR1); push(o + WD + WH, E_PR0);
            push(o + WD + WH + WL, E_PR2); push(o + WD + 2 * WH + WL, E_HREL);
            push(o + WD + 2 * WH + WL + 1, E_FLA);
        end
    endtask

    task automatic apply(input int id);
        case (id)
            E_IFEN: e_if = 1;
            E_TUNE: begin e_vref = {NP{4'd15}}; e_rise = {NP{2'd1}}; e_pre = '1; end
            E_RST0: {e_por, e_hrel, e_prst, e_hen, e_hrun, e_oen, e_orun} = 7'b1000000;
            E_REF: begin
                e_sel = !m_xtal; e_bad = 0;
                if (m_ref == 12_000_000) e_rdiv = 0;
                else if (m_ref == 24_000_000) e_rdiv = 1;
                else if (m_ref == 48_000_000) e_rdiv = 2;
                else begin e_rdiv = 0; e_bad = 1; end
            end
            E_HDIV: e_hdiv = exp_hdiv(m_io);
            E_HEN:  e_hen = 1;
            E_HRUN: e_hrun = 1;
            E_POR:  e_por = 0;
            E_ORUN: e_orun = 1;
            E_OEN:  e_oen = 1;
            E_PR1:  e_prst = 1;
            E_PR0:  e_prst = 0;
            E_PR2:  e_prst = 1;
            E_HREL: e_hrel = 1;
            E_FLA:  begin e_fla = 6'h20; e_done = 1; m_busy = 0; end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_reset();
        end else begin
            e_done = 0;
            if (start_req && !stop_req) begin
                if (m_cnt == 0 && !m_busy) m_launch();
                if (m_cnt < 15) m_cnt++;
            end else if (stop_req && !start_req && m_cnt > 0) begin
                m_cnt--;
            end
            while (evq.size() > 0 && evq[0].at == cyc) begin
                apply(evq[0].id);
                void'(evq.pop_front());
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input longint got, input longint exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check("R3 if_en", if_en, e_if);
            check("R3 vref", tx_vref_tune, e_vref);
            check("R3 rise", tx_rise_tune, e_rise);
            check("R3 preemph", tx_preemph_tune, e_pre);
            check("R6 refclk_sel", refclk_sel, e_sel);
            check("R6 refclk_div", refclk_div, e_rdiv);
            check("R6 bad_rate", bad_rate, e_bad);
            check("R7 host_div", host_div, e_hdiv);
            check("R8 host_div_en", host_div_en, e_hen);
            check("R8 host_div_run", host_div_run, e_hrun);
            check("R8 ohci_div_en", ohci_div_en, e_oen);
            check("R8 ohci_div_run", ohci_div_run, e_orun);
            check("R8 phy_por", phy_por, e_por);
            check("R9 phy_rst_drv", phy_rst_drv, e_prst);
            check("R9 host_rst_rel", host_rst_rel, e_hrel);
            check("R10 fla_adj", fla_adj, e_fla);
            check("R10 done", done, e_done);
            if (done) done_seen++;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150_000) begin
            bad++; total++;
            $display("FAIL watchdog: got %0d expected below 150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1; start_req = 0; stop_req = 0;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    // Returns at the negedge just after the launch edge.
    task automatic pulse_start();
        @(negedge clk); start_req = 1;
        @(negedge clk); start_req = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_req = 1;
        @(negedge clk); stop_req = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    endtask

    task automatic full_run(input int io, input int rf, input bit xt);
        do_reset();
        io_clk_hz = io; ref_clk_hz = rf; ref_is_crystal = xt;
        pulse_start();
        @(negedge clk);
        check("R3 if_en one edge after launch", if_en, 1);
        repeat (3) @(negedge clk);
        check("R5 phy_por asserted", phy_por, 1);
        check("R5 host_rst_rel low", host_rst_rel, 0);
        @(negedge clk);
        check("R6 refclk_sel", refclk_sel, !xt);
        @(negedge clk);
        check("R7 host_div band", host_div, exp_hdiv(io));
        wait_done();
        check("R10 done reached", done, 1);
    endtask

    int io_list[12] = '{100_000_000, 130_000_000, 300_000_000, 400_000_000,
                        520_000_000, 650_000_000, 800_000_000, 1_000_000_000,
                        1_040_000_000, 1_500_000_000, 1_560_000_000, 2_000_000_000};
    int rf_list[4] = '{12_000_000, 24_000_000, 48_000_000, 25_000_000};

    initial begin
        int d0;
        m_launches = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset outputs", {if_en, phy_por, host_rst_rel, done, bad_rate, fla_adj,
                                   host_div, tx_vref_tune}, 0);

        // R2: simultaneous start and stop at count 0 launches nothing
        @(negedge clk); start_req = 1; stop_req = 1;
        @(negedge clk); start_req = 0; stop_req = 0;
        repeat (6) @(negedge clk);
        check("R2 start+stop no launch", if_en, 0);

        for (int k = 0; k < 12; k++) full_run(io_list[k], rf_list[k % 4], k[0]);

        // R11: extra starts during a running sequence
        do_reset();
        io_clk_hz = 800_000_000; ref_clk_hz = 48_000_000;
        d0 = done_seen;
        pulse_start();
        repeat (10) @(negedge clk);
        pulse_start();
        pulse_start();
        wait_done();
        repeat (20) @(negedge clk);
        check("R11 single done for piled starts", done_seen - d0, 1);

        // R2: count is 3; two stops leave 1, start must not launch
        pulse_stop(); pulse_stop();
        d0 = done_seen;
        pulse_start();
        repeat (10) @(negedge clk);
        check("R2 start at nonzero count no launch", done_seen - d0, 0);
        pulse_stop(); pulse_stop(); pulse_stop();   // to 0, then a surplus stop

        // R4: skip path once host reset is already released
        d0 = done_seen;
        pulse_start();
        repeat (3) @(negedge clk);
        check("R4 skip done not yet", done, 0);
        @(negedge clk);
        check("R4 skip done at launch+4", done, 1);
        check("R4 skip phy_por untouched", phy_por, 0);
        check("R4 skip host_rst_rel kept", host_rst_rel, 1);
        repeat (5) @(negedge clk);
        check("R2 surplus stop ignored, one launch", done_seen - d0, 1);
        check("R2 total launches", done_seen, m_launches);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule